// File: doc/BRIEF.md
# Debug Control and Low-Power Handshake

This block holds the control word of a debug port. From the system clock it makes a trace clock at one of four ratios, and it can stop that clock automatically while no trace message is being sent. The same word drives the enable of the event port. It also runs two independent handshakes that keep the device from entering sleep or stop mode until an external debug tool has acknowledged the entry.

Software reads and writes one control word through a single-cycle write strobe and a combinational read path. The device raises a sleep or stop request. While low-power debug is enabled, the block marks the request as pending in the control word and holds back the matching grant. The grant is given only after the tool writes a 0 to that pending bit. While low-power debug is disabled, requests pass straight through to the grants.

Top module: `dbg_lp_ctrl`

## Requirements
- R1: After reset the control word reads 0, the trace clock, event enable and both grants are 0, and the divider is divide-by-1.
- R2: The 3-bit ratio field (bits 3:1) selects divide-by-1 (code 0), 2 (code 1), 4 (code 3) or 8 (code 7). For 2, 4 and 8 the trace clock is high for the first half of each period and low for the second half.
- R3: A write of any other ratio code (2, 4, 5 or 6) leaves the ratio field and the divider at their previous value.
- R4: While the trace enable bit (bit 0) is 0, the trace clock stays low from the next period boundary on.
- R5: A change of ratio or of enable takes effect only at a period boundary of the running divided clock.
- R6: With the auto-gate bit (bit 4) set, the trace clock stops at a period boundary once message-busy has been low for the whole period just ended. It restarts at the first boundary after busy is seen.
- R7: Auto-gating never stops the trace clock while divide-by-8 is selected.
- R8: The event enable output equals the event bit (bit 5) of the control word.
- R9: While the low-power debug bit (bit 6) is 0, each grant equals its request and both sync bits stay 0.
- R10: With bit 6 set, a sleep request sets the sleep-sync bit (bit 7) on the next cycle. The sleep grant stays 0 until the tool writes 0 to bit 7. The grant then rises on the next cycle and holds until the request falls.
- R11: Writing 1 to bit 7 or bit 8 never sets or keeps a sync bit. Writing 0 to a sync bit that is not pending has no effect.
- R12: Stop mode uses bit 8 and the stop request and grant, with the same rules as R10 and independent of the sleep handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Current control word |
| sleep_req | input | 1 | Device requests sleep entry |
| stop_req | input | 1 | Device requests stop entry |
| msg_busy | input | 1 | A trace message is in transmission |
| trc_clk | output | 1 | Divided trace clock |
| evt_en | output | 1 | Event port enable |
| sleep_gnt | output | 1 | Sleep entry allowed |
| stop_gnt | output | 1 | Stop entry allowed |

## Verification
The assertions assume that a device request, once raised, stays high until its grant arrives or low-power debug is turned off. They also assume that every input changes only between clock edges. The stimulus drives all inputs on the falling edge. It holds each request across its whole handshake and drops a request only after the grant has been seen or checked. Every write carries 1 in both sync bits unless the write is meant as an acknowledgement. This keeps a plain field update from acknowledging a pending entry by accident.

// File: rtl/dbg_lp_pkg.sv
// Shared constants, field positions and types for the debug control block.
// Assumes a single control word; all widths derive from the divider range.
package dbg_lp_pkg;
    localparam int MAX_LOG  = 3;                    // largest ratio is 2**MAX_LOG
    localparam int SEL_W    = $clog2(MAX_LOG + 1);
    localparam int CNT_W    = MAX_LOG;
    localparam int CODE_W   = 3;
    localparam int REG_W    = 9;
    localparam int B_TEN    = 0;
    localparam int B_CODE   = 1;
    localparam int B_GATE   = 4;
    localparam int B_EVT    = 5;
    localparam int B_LP     = 6;
    localparam int B_SLP    = 7;
    localparam int B_STP    = 8;

    typedef enum logic [1:0] {HS_IDLE, HS_PEND, HS_GRANT} hs_state_e;

    // Accepted ratio codes are those whose ones are packed at the bottom.
    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        return (c == 3'b000) || (c == 3'b001) || (c == 3'b011) || (c == 3'b111);
    endfunction

    // Log2 of the ratio equals the number of ones in a legal code.
    function automatic logic [SEL_W-1:0] code_sel(input logic [CODE_W-1:0] c);
        logic [SEL_W-1:0] s;
        s = '0;
        for (int i = 0; i < CODE_W; i++) s = s + SEL_W'(c[i]);
        return s;
    endfunction
endpackage

// File: rtl/dbg_lp_regs.sv
// Control field storage. Ratio writes with an unaccepted code are dropped.
// Assumes one write port; sync bits live in the handshake units.
module dbg_lp_regs
    import dbg_lp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    output logic              trc_en,
    output logic              gate_en,
    output logic              evt_bit,
    output logic              lp_en,
    output logic [CODE_W-1:0] code,
    output logic [SEL_W-1:0]  sel
);
    logic [CODE_W-1:0] new_code;

    assign new_code = wdata[B_CODE +: CODE_W];
    assign sel      = code_sel(code);

    // Capture enables on every write, ratio only when the code is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trc_en  <= 1'b0;
            gate_en <= 1'b0;
            evt_bit <= 1'b0;
            lp_en   <= 1'b0;
            code    <= '0;
        end else if (wr) begin
            trc_en  <= wdata[B_TEN];
            gate_en <= wdata[B_GATE];
            evt_bit <= wdata[B_EVT];
            lp_en   <= wdata[B_LP];
            if (code_legal(new_code)) code <= new_code;
        end
    end
endmodule

// File: rtl/dbg_lp_hshk.sv
// One low-power entry handshake: hardware marks pending, tool acknowledges by
// writing 0. Assumes req is held until granted or low-power debug is off.
module dbg_lp_hshk
    import dbg_lp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lp_en,
    input  logic req,
    input  logic ack_wr,
    output logic sync,
    output logic gnt
);
    hs_state_e st, st_nx;

    // Next state of the handshake.
    always_comb begin
        st_nx = st;
        if (!lp_en) st_nx = HS_IDLE;
        else begin
            unique case (st)
                HS_IDLE:  if (req) st_nx = HS_PEND;
                HS_PEND:  if (!req) st_nx = HS_IDLE; else if (ack_wr) st_nx = HS_GRANT;
                HS_GRANT: if (!req) st_nx = HS_IDLE;
                default:  st_nx = HS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= HS_IDLE;
        else        st <= st_nx;
    end

    assign sync = (st == HS_PEND);
    assign gnt  = lp_en ? (st == HS_GRANT) : req;
endmodule

// File: rtl/dbg_lp_clkdiv.sv
// Trace clock divider with boundary-only updates and optional idle gating.
// Assumes the system clock is free-running; the ratio is 2**sel.
module dbg_lp_clkdiv
    import dbg_lp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trc_en,
    input  logic             gate_en,
    input  logic [SEL_W-1:0] req_sel,
    input  logic             msg_busy,
    output logic             trc_clk
);
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(MAX_LOG);

    logic [SEL_W-1:0] cur_sel;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cur_n;
    logic [CNT_W:0]   cnt_inc;
    logic             bnd, ph_q, run_q, busy_seen, en_lat, idle_per;

    assign cur_n    = (CNT_W+1)'(1) << cur_sel;
    assign cnt_inc  = {1'b0, cnt} + 1'b1;
    assign bnd      = (cnt_inc == cur_n);
    assign idle_per = !(busy_seen || msg_busy);

    // Period counter, ratio/run update at boundaries, phase of divided clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            cur_sel   <= '0;
            run_q     <= 1'b0;
            ph_q      <= 1'b0;
            busy_seen <= 1'b0;
        end else if (bnd) begin
            cnt       <= '0;
            cur_sel   <= req_sel;
            run_q     <= trc_en && !(gate_en && (req_sel != SEL_MAX) && idle_per);
            ph_q      <= (req_sel != '0);
            busy_seen <= 1'b0;
        end else begin
            cnt       <= cnt_inc[CNT_W-1:0];
            ph_q      <= (cnt_inc < (cur_n >> 1));
            busy_seen <= busy_seen || msg_busy;
        end
    end

    // Enable for the undivided path, changed only while clk is low.
    always_ff @(negedge clk) begin
        if (!rst_n) en_lat <= 1'b0;
        else        en_lat <= run_q;
    end

    assign trc_clk = (cur_sel == '0) ? (clk & en_lat) : (ph_q & run_q);
endmodule

// File: rtl/dbg_lp_ctrl.sv
// Top: control word, trace clock divider and two low-power handshakes.
// Assumes inputs are synchronous to clk.
module dbg_lp_ctrl
    import dbg_lp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sleep_req,
    input  logic             stop_req,
    input  logic             msg_busy,
    output logic             trc_clk,
    output logic             evt_en,
    output logic             sleep_gnt,
    output logic             stop_gnt
);
    localparam int N_HS = 2;

    logic              trc_en, gate_en, evt_bit, lp_en;
    logic [CODE_W-1:0] code;
    logic [SEL_W-1:0]  sel;
    logic [N_HS-1:0]   hs_req, hs_sync, hs_gnt, hs_ack;

    dbg_lp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .trc_en(trc_en), .gate_en(gate_en), .evt_bit(evt_bit),
        .lp_en(lp_en), .code(code), .sel(sel)
    );

    dbg_lp_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .trc_en(trc_en), .gate_en(gate_en),
        .req_sel(sel), .msg_busy(msg_busy), .trc_clk(trc_clk)
    );

    assign hs_req = {stop_req, sleep_req};

    for (genvar g = 0; g < N_HS; g++) begin : g_hs
        assign hs_ack[g] = reg_wr && !reg_wdata[B_SLP + g];
        dbg_lp_hshk u_hs (
            .clk(clk), .rst_n(rst_n), .lp_en(lp_en), .req(hs_req[g]),
            .ack_wr(hs_ack[g]), .sync(hs_sync[g]), .gnt(hs_gnt[g])
        );
    end

    assign sleep_gnt = hs_gnt[0];
    assign stop_gnt  = hs_gnt[1];
    assign evt_en    = evt_bit;
    assign reg_rdata = {hs_sync[1], hs_sync[0], lp_en, evt_bit, gate_en, code, trc_en};
endmodule

// File: rtl/dbg_lp_ctrl_chk.sv
// Property checker for dbg_lp_ctrl, attached by bind.
module dbg_lp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [8:0] reg_rdata,
    input logic       sleep_req,
    input logic       stop_req,
    input logic       sleep_gnt,
    input logic       stop_gnt
);
    logic lp, ssync, psync;
    logic [2:0] c;
    assign lp    = reg_rdata[6];
    assign ssync = reg_rdata[7];
    assign psync = reg_rdata[8];
    assign c     = reg_rdata[3:1];

    AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 3'd0) || (c == 3'd1) || (c == 3'd3) || (c == 3'd7)); // R3
    AST_NOLP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !lp |-> (sleep_gnt == sleep_req) && (stop_gnt == stop_req)); // R9
    AST_SLEEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        lp && ssync |-> !sleep_gnt); // R10
    AST_SLEEP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        lp && $past(lp) && $rose(sleep_gnt) |-> $past(ssync)); // R10
    AST_SYNC_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ssync) |-> $past(sleep_req) && $past(lp)); // R11
    AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        lp && psync |-> !stop_gnt); // R12
    AST_STOP_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psync) |-> $past(stop_req) && $past(lp)); // R12
endmodule

bind dbg_lp_ctrl dbg_lp_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata),
    .sleep_req(sleep_req), .stop_req(stop_req),
    .sleep_gnt(sleep_gnt), .stop_gnt(stop_gnt)
);

// File: tb/dbg_lp_ctrl_tb_top.sv
// Bench with a behavioural per-cycle model plus directed checks.
module dbg_lp_ctrl_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
    logic [8:0] reg_wdata = '0;
    logic [8:0] reg_rdata;
    logic sleep_req = 1'b0, stop_req = 1'b0, msg_busy = 1'b0;
    logic trc_clk, evt_en, sleep_gnt, stop_gnt;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg_lp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_req(sleep_req), .stop_req(stop_req),
        .msg_busy(msg_busy), .trc_clk(trc_clk), .evt_en(evt_en),
        .sleep_gnt(sleep_gnt), .stop_gnt(stop_gnt)
    );

    // Behavioural model state.
    int m_ten, m_gate, m_evt, m_lp, m_code;
    int m_slp, m_stp;                 // 0 idle, 1 pending, 2 granted
    int m_div, m_pos, m_run, m_busy, m_lat;

    function automatic int ratio_of(int c);
        case (c) 0: return 1; 1: return 2; 3: return 4; 7: return 8; default: return -1;
        endcase
    endfunction

    function automatic int hs_next(int st, int lp, int rq, int ack);
        if (lp == 0) return 0;
        if (st == 0) return rq ? 1 : 0;
        if (st == 1) return !rq ? 0 : (ack ? 2 : 1);
        return rq ? 2 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ten = 0; m_gate = 0; m_evt = 0; m_lp = 0; m_code = 0;
            m_slp = 0; m_stp = 0;
            m_div = 1; m_pos = 0; m_run = 0; m_busy = 0; m_lat = 0;
        end else begin
            m_slp = hs_next(m_slp, m_lp, sleep_req, reg_wr && !reg_wdata[7]);
            m_stp = hs_next(m_stp, m_lp, stop_req,  reg_wr && !reg_wdata[8]);
            m_lat = m_run;
            if (m_pos == m_div - 1) begin
                m_div  = ratio_of(m_code);
                m_run  = m_ten && !(m_gate && m_div != 8 && !(m_busy || msg_busy));
                m_pos  = 0;
                m_busy = 0;
            end else begin
                m_pos  = m_pos + 1;
                m_busy = m_busy || msg_busy;
            end
            if (reg_wr) begin
                m_ten = reg_wdata[0]; m_gate = reg_wdata[4];
                m_evt = reg_wdata[5]; m_lp = reg_wdata[6];
                if (ratio_of(reg_wdata[3:1]) > 0) m_code = reg_wdata[3:1];
            end
        end
    end

    function automatic logic [8:0] exp_rdata();
        return 9'({m_stp == 1, m_slp == 1, m_lp[0], m_evt[0], m_gate[0], m_code[2:0], m_ten[0]});
    endfunction

    function automatic logic exp_trc();
        if (m_div == 1) return m_lat != 0;
        return (m_run != 0) && (m_pos < m_div / 2);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of every output against the model.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && !done) begin
                check(reg_rdata == exp_rdata(), "R11 word", reg_rdata, exp_rdata());
                check(trc_clk == exp_trc(), "R2 trace", trc_clk, exp_trc());
                check(evt_en == m_evt[0], "R8 event", evt_en, m_evt);
                check(sleep_gnt == (m_lp ? (m_slp == 2) : sleep_req), "R10 sleep_gnt", sleep_gnt, m_slp);
                check(stop_gnt == (m_lp ? (m_stp == 2) : stop_req), "R12 stop_gnt", stop_gnt, m_stp);
            end
        end
    end

    task automatic wr(input logic [8:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // Build a word with both sync bits written as 1 (no acknowledgement).
    function automatic logic [8:0] word(int ten, int code, int gate, int evt, int lp);
        return {1'b1, 1'b1, lp[0], evt[0], gate[0], code[2:0], ten[0]};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        repeat (n) begin @(posedge clk); #1; if (trc_clk) h++; end
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int h;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        check(reg_rdata == 9'd0, "R1 word", reg_rdata, 0);
        check({trc_clk, evt_en, sleep_gnt, stop_gnt} == 4'd0, "R1 outputs", {trc_clk, evt_en, sleep_gnt, stop_gnt}, 0);

        // R2 divide by 1, 2, 4, 8; R5 changes land on boundaries
        wr(word(1, 0, 0, 0, 0)); idle(3);
        count_high(8, h); check(h == 8, "R2 div1", h, 8);
        wr(word(1, 1, 0, 0, 0)); idle(4);
        count_high(8, h); check(h == 4, "R2 div2", h, 4);
        wr(word(1, 3, 0, 0, 0)); idle(6);
        count_high(16, h); check(h == 8, "R2 div4", h, 8);
        wr(word(1, 7, 0, 0, 0)); idle(10);
        count_high(16, h); check(h == 8, "R2 div8", h, 8);
        idle(3); wr(word(1, 1, 0, 0, 0)); idle(12);   // R5 mid-period change
        wr(word(1, 7, 0, 0, 0)); idle(12);

        // R3 reserved codes ignored
        wr(word(1, 2, 0, 0, 0)); @(posedge clk); #1;
        check(reg_rdata[3:1] == 3'd7, "R3 code2", reg_rdata[3:1], 7);
        wr(word(1, 5, 0, 0, 0)); @(posedge clk); #1;
        check(reg_rdata[3:1] == 3'd7, "R3 code5", reg_rdata[3:1], 7);
        count_high(16, h); check(h == 8, "R3 ratio kept", h, 8);

        // R4 disable
        wr(word(0, 7, 0, 0, 0)); idle(10);
        count_high(16, h); check(h == 0, "R4 off", h, 0);

        // R6 auto gating at div2
        @(negedge clk); msg_busy = 1'b1;
        wr(word(1, 1, 1, 0, 0)); idle(6);
        count_high(6, h); check(h > 0, "R6 busy runs", h, 3);
        @(negedge clk); msg_busy = 1'b0; idle(8);
        count_high(8, h); check(h == 0, "R6 gated", h, 0);
        @(negedge clk); msg_busy = 1'b1; idle(4);
        count_high(8, h); check(h == 4, "R6 resumed", h, 4);
        @(negedge clk); msg_busy = 1'b0;

        // R7 no gating at div8
        wr(word(1, 7, 1, 0, 0)); idle(24);
        count_high(16, h); check(h == 8, "R7 div8 ungated", h, 8);

        // R8 event enable
        wr(word(1, 7, 1, 1, 0)); @(posedge clk); #1;
        check(evt_en == 1'b1, "R8 on", evt_en, 1);
        wr(word(1, 7, 1, 0, 0)); @(posedge clk); #1;
        check(evt_en == 1'b0, "R8 off", evt_en, 0);

        // R9 pass-through without low-power debug
        @(negedge clk); sleep_req = 1'b1; stop_req = 1'b1;
        @(posedge clk); #1;
        check(sleep_gnt && stop_gnt && reg_rdata[8:7] == 2'b00, "R9", {sleep_gnt, stop_gnt, reg_rdata[8:7]}, 12);
        @(negedge clk); sleep_req = 1'b0; stop_req = 1'b0;

        // R10 sleep handshake, R11 write-one ignored
        wr(word(0, 0, 0, 0, 1));
        @(negedge clk); sleep_req = 1'b1;
        @(posedge clk); #1;
        check(reg_rdata[7] && !sleep_gnt, "R10 pending", {reg_rdata[7], sleep_gnt}, 2);
        wr(word(0, 0, 0, 0, 1)); @(posedge clk); #1;
        check(reg_rdata[7] && !sleep_gnt, "R11 write1", {reg_rdata[7], sleep_gnt}, 2);
        wr(9'h040 | 9'h100);                       // bit7 = 0 acknowledges sleep
        @(posedge clk); #1;
        check(!reg_rdata[7] && sleep_gnt, "R10 granted", {reg_rdata[7], sleep_gnt}, 1);

        // R12 stop independent while sleep stays granted
        @(negedge clk); stop_req = 1'b1;
        @(posedge clk); #1;
        check(reg_rdata[8] && !stop_gnt && sleep_gnt, "R12 pending", {reg_rdata[8], stop_gnt, sleep_gnt}, 5);
        wr(9'h040 | 9'h080);                       // bit8 = 0 acknowledges stop
        @(posedge clk); #1;
        check(!reg_rdata[8] && stop_gnt && sleep_gnt, "R12 granted", {reg_rdata[8], stop_gnt, sleep_gnt}, 3);
        @(negedge clk); sleep_req = 1'b0; stop_req = 1'b0;
        wr(9'h040);                                // R11 zero write when idle
        @(posedge clk); #1;
        check(reg_rdata[8:7] == 2'b00 && !sleep_gnt, "R11 idle zero", reg_rdata[8:7], 0);
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule